// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block connects a processor-side request port to an external memory bus with two 8-bit lanes. A request gives an operand size (8, 16 or 32 bits), a byte address, write data and a direction. The block breaks the request into one to four external bus cycles. For each cycle it drives the bus address and the chip select of the addressed area. On a write it places each operand byte on the correct lane and strobes only the lanes it fills. On a read it gathers the bytes that come back and puts them together into the operand.

Lane steering depends on three things: the operand size, the low address bit, and the width of the addressed memory. The top two address bits select one of four areas. Each area has an enable bit and a width bit, and both are written through a small configuration port. After reset only area 2 is enabled, and every area is set to the wide width. An access to a disabled area runs as a 16-bit access and raises no chip select. When the last cycle of a request has finished, `done` pulses for one clock and the assembled read operand appears on `rdata`.

Top module: `lane_split_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0, `bus_rd`, `bus_wr` and `bus_cs` are 0, area 2 is enabled, areas 0, 1 and 3 are disabled, and every area uses the 16-bit width.
- R2: The area is `req_addr[15:14]`. When the area is enabled, its width bit selects the bus width: 1 means an 8-bit bus, 0 means a 16-bit bus. A disabled area is accessed as a 16-bit bus. A `cfg_we` pulse writes `cfg_enable` and `cfg_narrow` into the area `cfg_area`.
- R3: During every bus cycle of an enabled area, `bus_cs` is one-hot with bit `area` set. For a disabled area `bus_cs` is 0. Outside bus cycles `bus_cs` is 0.
- R4: An 8-bit operand takes one cycle at its own address. It uses the low lane (bits 7..0) on an 8-bit bus. On a 16-bit bus it uses the low lane at an even address and the high lane (bits 15..8) at an odd address.
- R5: A 16-bit operand on an 8-bit bus takes two low-lane cycles: byte 0 at address A, then byte 1 at A+1.
- R6: A 16-bit operand on a 16-bit bus takes one cycle at an even A, with byte 0 low and byte 1 high. At an odd A it takes two cycles: byte 0 high at A, then byte 1 low at A+1.
- R7: A 32-bit operand on an 8-bit bus takes four low-lane cycles at A, A+1, A+2 and A+3, carrying bytes 0, 1, 2 and 3 in that order.
- R8: A 32-bit operand at an even A on a 16-bit bus takes two cycles: bytes 1:0 at A, then bytes 3:2 at A+2, with the higher byte of each pair on the high lane.
- R9: A 32-bit operand at an odd A on a 16-bit bus takes three cycles: byte 0 high at A; then byte 1 low and byte 2 high at A+1; then byte 3 low at A+3.
- R10: `bus_we_lo` and `bus_we_hi` are the write strobe and the output enable of each lane. A lane that is not in use keeps its strobe at 0 and drives 0 on `bus_dout`, which stands for high impedance. On reads both strobes stay 0, and data on an unused lane of `bus_din` is ignored.
- R11: Read bytes are stored at their operand positions, and operand bytes beyond the size read as 0. `done` is high for exactly one clock, N+1 cycles after the accepting edge, where N is the number of bus cycles. At that point `rdata` holds the operand.
- R12: `req_ready` is 1 exactly when the block is idle. A request presented while the block is busy is ignored. Size codes: 0 means 8 bits, 1 means 16 bits, 2 means 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for area configuration |
| cfg_area | input | 2 | Area to configure |
| cfg_enable | input | 1 | New enable bit for that area |
| cfg_narrow | input | 1 | New width bit for that area (1 = 8-bit bus) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_size | input | 2 | Operand size code |
| req_addr | input | 16 | Operand start byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write operand, byte 0 in bits 7..0 |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Assembled read operand |
| bus_addr | output | 16 | Bus cycle byte address |
| bus_cs | output | 4 | Per-area chip selects |
| bus_rd | output | 1 | Read bus cycle in progress |
| bus_wr | output | 1 | Write bus cycle in progress |
| bus_we_lo | output | 1 | Low lane write strobe / output enable |
| bus_we_hi | output | 1 | High lane write strobe / output enable |
| bus_dout | output | 16 | Write data on both lanes |
| bus_din | input | 16 | Read data from both lanes |

## Verification
A request is accepted on a clock edge. Its first bus cycle is visible in the clock that follows, and each later cycle appears one clock after the previous one. `done` and the final `rdata` then arrive one clock after the last bus cycle. The bench samples every result on the falling edge. A scoreboard pops one expected bus cycle for each falling edge at which `bus_rd` or `bus_wr` is high. The driver counts falling edges from acceptance and expects `done` at count N+1. Because of that fixed delay, an extra, missing or reordered cycle shows up as a mismatch at a known edge.

// File: rtl/lane_split_pkg.sv
package lane_split_pkg;

    typedef enum logic [1:0] {
        OP_B8  = 2'd0,
        OP_B16 = 2'd1,
        OP_B32 = 2'd2
    } opsize_e;

    // What a single bus cycle does with the operand
    typedef struct packed {
        logic [1:0] off;      // added to the start address
        logic       lo_use;
        logic       hi_use;
        logic [1:0] lo_byte;  // operand byte carried on the low lane
        logic [1:0] hi_byte;  // operand byte carried on the high lane
        logic       last;
    } lane_step_t;

endpackage

// File: rtl/lane_split_plan.sv
module lane_split_plan
    import lane_split_pkg::*;
(
    input  logic [1:0]  size,
    input  logic        odd_start,
    input  logic        narrow,
    input  logic [1:0]  step,
    output lane_step_t  plan
);

    logic [2:0] nbytes;
    logic [2:0] off3;
    logic [2:0] lob;
    logic [2:0] hib;
    logic [2:0] top;
    logic       first_odd;

    always_comb begin
        case (size)
            OP_B8:   nbytes = 3'd1;
            OP_B16:  nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
        first_odd = odd_start && (step == 2'd0);
        plan      = '0;
        if (narrow) begin
            // one byte per cycle, always on the low lane
            off3        = {1'b0, step};
            lob         = off3;
            hib         = 3'd7;
            plan.lo_use = 1'b1;
            plan.hi_use = 1'b0;
            top         = lob;
        end else begin
            // wide bus: each cycle after the first begins at an even address
            off3        = (step == 2'd0) ? 3'd0 : ({step, 1'b0} - {2'b00, odd_start});
            lob         = off3;
            hib         = first_odd ? 3'd0 : off3 + 3'd1;
            plan.lo_use = !first_odd && (lob < nbytes);
            plan.hi_use = hib < nbytes;
            top         = plan.hi_use ? hib : lob;
        end
        plan.off     = off3[1:0];
        plan.lo_byte = lob[1:0];
        plan.hi_byte = hib[1:0];
        plan.last    = (top == nbytes - 3'd1);
    end

endmodule

// File: rtl/lane_split_areas.sv
module lane_split_areas #(
    parameter int AREAS       = 4,
    parameter int AREA_W      = 2,
    parameter int ON_AT_RESET = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AREA_W-1:0] cfg_idx,
    input  logic              cfg_en,
    input  logic              cfg_nar,
    input  logic [AREA_W-1:0] look_idx,
    output logic              narrow_o,
    output logic [AREAS-1:0]  cs_o
);

    typedef struct packed {
        logic [AREAS-1:0] en;
        logic [AREAS-1:0] nar;
    } area_regs_t;

    area_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            r_d.en[cfg_idx]  = cfg_en;
            r_d.nar[cfg_idx] = cfg_nar;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.en  <= AREAS'(1) << ON_AT_RESET;
            r_q.nar <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // a disabled area falls back to the wide bus
    assign narrow_o = r_q.en[look_idx] && r_q.nar[look_idx];

    for (genvar g = 0; g < AREAS; g++) begin : g_cs
        assign cs_o[g] = (look_idx == AREA_W'(g)) && r_q.en[g];
    end

    p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (r_q.en[$past(cfg_idx)] == $past(cfg_en))
                && (r_q.nar[$past(cfg_idx)] == $past(cfg_nar)));

    p_cs_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o) && ((cs_o & ~r_q.en) == '0));

endmodule

// File: rtl/lane_split_seq.sv
module lane_split_seq
    import lane_split_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int AREAS  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [$clog2(AREAS)-1:0]   cfg_area,
    input  logic                       cfg_enable,
    input  logic                       cfg_narrow,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [1:0]                 req_size,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_write,
    input  logic [31:0]                req_wdata,
    output logic                       done,
    output logic [31:0]                rdata,
    output logic [ADDR_W-1:0]          bus_addr,
    output logic [AREAS-1:0]           bus_cs,
    output logic                       bus_rd,
    output logic                       bus_wr,
    output logic                       bus_we_lo,
    output logic                       bus_we_hi,
    output logic [15:0]                bus_dout,
    input  logic [15:0]                bus_din
);

    localparam int AREA_W = $clog2(AREAS);

    typedef struct packed {
        logic              busy;
        logic [1:0]        step;
        logic [1:0]        size;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [31:0]       wdata;
        logic              narrow;
        logic [AREAS-1:0]  cs;
        logic [31:0]       hold;
        logic              done;
    } seq_state_t;

    seq_state_t s_d, s_q;
    lane_step_t plan;
    logic              area_narrow;
    logic [AREAS-1:0]  area_cs;

    lane_split_areas #(
        .AREAS       (AREAS),
        .AREA_W      (AREA_W),
        .ON_AT_RESET (2)
    ) i_areas (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_area),
        .cfg_en   (cfg_enable),
        .cfg_nar  (cfg_narrow),
        .look_idx (req_addr[ADDR_W-1 -: AREA_W]),
        .narrow_o (area_narrow),
        .cs_o     (area_cs)
    );

    lane_split_plan i_plan (
        .size      (s_q.size),
        .odd_start (s_q.addr[0]),
        .narrow    (s_q.narrow),
        .step      (s_q.step),
        .plan      (plan)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (req_valid) begin
                s_d.busy   = 1'b1;
                s_d.step   = 2'd0;
                s_d.size   = req_size;
                s_d.addr   = req_addr;
                s_d.write  = req_write;
                s_d.wdata  = req_wdata;
                s_d.narrow = area_narrow;
                s_d.cs     = area_cs;
                s_d.hold   = '0;
            end
        end else begin
            if (!s_q.write) begin
                if (plan.lo_use) s_d.hold[{plan.lo_byte, 3'b000} +: 8] = bus_din[7:0];
                if (plan.hi_use) s_d.hold[{plan.hi_byte, 3'b000} +: 8] = bus_din[15:8];
            end
            if (plan.last) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.step = s_q.step + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready = !s_q.busy;
    assign done      = s_q.done;
    assign rdata     = s_q.hold;
    assign bus_rd    = s_q.busy && !s_q.write;
    assign bus_wr    = s_q.busy && s_q.write;
    assign bus_cs    = s_q.busy ? s_q.cs : '0;
    assign bus_addr  = s_q.addr + ADDR_W'(plan.off);
    assign bus_we_lo = bus_wr && plan.lo_use;
    assign bus_we_hi = bus_wr && plan.hi_use;
    assign bus_dout  = {bus_we_hi ? s_q.wdata[{plan.hi_byte, 3'b000} +: 8] : 8'h00,
                        bus_we_lo ? s_q.wdata[{plan.lo_byte, 3'b000} +: 8] : 8'h00};

    p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_cs));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs == '0) && !bus_rd && !bus_wr);

    p_strobe_write_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_lo || bus_we_hi) |-> bus_wr);

    p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> !req_ready);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bus_rd || bus_wr));

endmodule

// File: tb/test_lane_split_seq.sv
module test_lane_split_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_area = '0;
    logic        cfg_enable = 1'b0;
    logic        cfg_narrow = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_size = '0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        done;
    logic [31:0] rdata;
    logic [15:0] bus_addr;
    logic [3:0]  bus_cs;
    logic        bus_rd, bus_wr, bus_we_lo, bus_we_hi;
    logic [15:0] bus_dout;
    logic [15:0] bus_din;

    always #2 clk = ~clk;

    lane_split_seq i_lane_split_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_area(cfg_area),
        .cfg_enable(cfg_enable), .cfg_narrow(cfg_narrow),
        .req_valid(req_valid), .req_ready(req_ready), .req_size(req_size),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .bus_addr(bus_addr), .bus_cs(bus_cs),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_we_lo(bus_we_lo),
        .bus_we_hi(bus_we_hi), .bus_dout(bus_dout), .bus_din(bus_din)
    );

    typedef struct {
        logic [15:0] addr;
        logic [3:0]  cs;
        logic        wr;
        logic        lo;
        logic        hi;
        logic [7:0]  dlo;
        logic [7:0]  dhi;
        string       req;
    } cyc_t;

    cyc_t        expq[$];
    int          checks = 0;
    int          fails = 0;
    bit          finished = 0;
    logic [3:0]  tb_en = 4'b0100;
    logic [3:0]  tb_nar = 4'b0000;

    function automatic logic [7:0] memv(input logic [15:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h3C;
    endfunction

    // memory model: the narrow bus puts junk on the high lane, the wide bus returns the even/odd pair
    always_comb begin
        if (tb_en[bus_addr[15:14]] && tb_nar[bus_addr[15:14]])
            bus_din = {8'hA5, memv(bus_addr)};
        else
            bus_din = {memv(bus_addr | 16'h0001), memv(bus_addr & 16'hFFFE)};
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: one expected item per observed bus cycle
    always @(negedge clk) begin : mon
        cyc_t c;
        if (rst_n && (bus_rd || bus_wr)) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R12 unexpected cycle", {16'h0, bus_addr}, 32'hFFFF_FFFF);
            end else begin
                c = expq.pop_front();
                chk(bus_addr == c.addr, c.req, {16'h0, bus_addr}, {16'h0, c.addr});
                chk(bus_cs == c.cs, "R3", {28'h0, bus_cs}, {28'h0, c.cs});
                chk(bus_wr == c.wr && bus_rd == !c.wr, c.req, {30'h0, bus_wr, bus_rd}, {30'h0, c.wr, !c.wr});
                chk({bus_we_hi, bus_we_lo} == {c.hi & c.wr, c.lo & c.wr}, "R10",
                    {30'h0, bus_we_hi, bus_we_lo}, {30'h0, c.hi & c.wr, c.lo & c.wr});
                if (c.wr)
                    chk(bus_dout == {c.hi ? c.dhi : 8'h00, c.lo ? c.dlo : 8'h00}, c.req,
                        {16'h0, bus_dout}, {16'h0, c.hi ? c.dhi : 8'h00, c.lo ? c.dlo : 8'h00});
            end
        end
    end

    task automatic cfg(input logic [1:0] idx, input logic en, input logic nw);
        @(negedge clk);
        cfg_we = 1'b1; cfg_area = idx; cfg_enable = en; cfg_narrow = nw;
        tb_en[idx] = en; tb_nar[idx] = nw;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: builds the expected bus cycles byte by byte, then issues the request
    task automatic op(input logic [1:0] sz, input logic [15:0] a, input bit wr,
                      input logic [31:0] wd, input string req);
        int          n;
        int          ncyc;
        int          cnt;
        bit          nar;
        bit          open;
        logic [3:0]  cs;
        logic [31:0] er;
        logic [15:0] ad;
        logic [7:0]  bv;
        cyc_t        c;
        n    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        nar  = tb_en[a[15:14]] && tb_nar[a[15:14]];
        cs   = tb_en[a[15:14]] ? (4'b0001 << a[15:14]) : 4'b0000;
        er   = '0;
        open = 0;
        ncyc = 0;
        for (int k = 0; k < n; k++) begin
            ad = a + 16'(k);
            bv = wr ? wd[8*k +: 8] : memv(ad);
            if (!wr) er[8*k +: 8] = memv(ad);
            if (nar || k == 0 || !ad[0]) begin
                if (open) expq.push_back(c);
                c.addr = ad; c.cs = cs; c.wr = wr; c.lo = 0; c.hi = 0;
                c.dlo = 8'h00; c.dhi = 8'h00; c.req = req;
                open = 1;
                ncyc++;
            end
            if (nar || !ad[0]) begin c.lo = 1; c.dlo = bv; end
            else begin c.hi = 1; c.dhi = bv; end
        end
        expq.push_back(c);
        @(negedge clk);
        req_valid = 1'b1; req_size = sz; req_addr = a; req_write = wr; req_wdata = wd;
        @(negedge clk);
        cnt = 1;
        chk(req_ready == 1'b0, "R12 ready while busy", {31'h0, req_ready}, 32'h0);
        // a competing request while busy must be dropped
        req_size = 2'd2; req_addr = a ^ 16'h0101; req_write = !wr; req_wdata = ~wd;
        @(negedge clk);
        cnt = 2;
        req_valid = 1'b0;
        while (!done && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == ncyc + 1, "R11 done timing", cnt, ncyc + 1);
        if (!wr) chk(rdata == er, req, rdata, er);
        chk(expq.size() == 0, req, expq.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R11 done width", {31'h0, done}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", {31'h0, req_ready}, 32'h1);
        chk(done == 1'b0, "R1 done", {31'h0, done}, 32'h0);
        chk({bus_rd, bus_wr} == 2'b00, "R1 bus idle", {30'h0, bus_rd, bus_wr}, 32'h0);
        chk(bus_cs == 4'h0, "R1 cs", {28'h0, bus_cs}, 32'h0);

        // area 2: enabled and wide after reset
        op(2'd0, 16'h8010, 0, 32'h0, "R4 byte even wide rd");
        op(2'd0, 16'h8013, 0, 32'h0, "R4 byte odd wide rd");
        op(2'd0, 16'h8015, 1, 32'h0000_00C7, "R4 byte odd wide wr");
        op(2'd1, 16'h8020, 0, 32'h0, "R6 half even wide rd");
        op(2'd1, 16'h8021, 0, 32'h0, "R6 half odd wide rd");
        op(2'd1, 16'h8023, 1, 32'h0000_B1E2, "R6 half odd wide wr");
        op(2'd2, 16'h8030, 0, 32'h0, "R8 word even wide rd");
        op(2'd2, 16'h8034, 1, 32'h1234_5678, "R8 word even wide wr");
        op(2'd2, 16'h8041, 0, 32'h0, "R9 word odd wide rd");
        op(2'd2, 16'h8047, 1, 32'hDEAD_BEEF, "R9 word odd wide wr");

        // area 0 disabled: wide, no chip select, even if marked narrow
        cfg(2'd0, 1'b0, 1'b1);
        op(2'd2, 16'h0011, 0, 32'h0, "R2 disabled area rd");

        // area 1 enabled and narrow
        cfg(2'd1, 1'b1, 1'b1);
        op(2'd0, 16'h4007, 0, 32'h0, "R4 byte narrow rd");
        op(2'd0, 16'h4009, 1, 32'h0000_005A, "R4 byte narrow wr");
        op(2'd1, 16'h4011, 0, 32'h0, "R5 half narrow rd");
        op(2'd1, 16'h4012, 1, 32'h0000_9C3D, "R5 half narrow wr");
        op(2'd2, 16'h4021, 0, 32'h0, "R7 word narrow rd");
        op(2'd2, 16'h4030, 1, 32'hA1B2_C3D4, "R7 word narrow wr");

        // area 3 enabled wide; area 2 switched to narrow
        cfg(2'd3, 1'b1, 1'b0);
        op(2'd2, 16'hC105, 1, 32'h0F1E_2D3C, "R9 word odd area3 wr");
        cfg(2'd2, 1'b1, 1'b1);
        op(2'd1, 16'h8101, 1, 32'h0000_7788, "R2 width switch wr");
        op(2'd2, 16'h8103, 0, 32'h0, "R2 width switch rd");

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL R11 watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule